// File: doc/BRIEF.md
# Sequential Set-Bit Counter

This block returns how many bits are set in an input word. Instead of one wide adder tree, it walks the word one bit at a time. A small controller steps a shared datapath through a fixed sequence of register transfers. The datapath has a four-entry register file, one ALU and a one-bit right shifter.

After a start pulse, the block captures the word and clears the running total. It then builds a mask of one. The loop ANDs the word's low bit into a temporary, adds that temporary to the total, and shifts the word right. The loop repeats until the shifted word is zero. The result is then presented on the count output and the done flag rises.

The result and done stay up until the next start is accepted. Between runs the count output is disabled and reads zero. The run time depends on where the highest set bit sits, not on how many bits are set.

Top module: `bitcount_seq`

## Requirements
- R1: While rst_ni is low, and after it is released, done_o is 0, count_o is 0 and the block is idle.
- R2: When idle, start_i high at a rising edge begins a run. data_i is captured at the following rising edge and must be held until then. With start_i low, the block stays idle.
- R3: When done_o rises, count_o equals the number of ones in the captured word.
- R4: Let n be the index of the highest set bit plus one, or 1 for a zero word. done_o first reads high 4+3n rising edges after the edge that accepted start_i.
- R5: A zero word yields count 0 after a single loop pass, so done_o rises 7 edges after acceptance.
- R6: Once high, done_o and count_o hold their values while start_i stays low. done_o falls at the edge that accepts the next start.
- R7: While done_o is low, count_o reads 0.
- R8: start_i is ignored while a run is in progress. It changes neither the result nor the latency.
- R9: An all-ones word yields a count equal to the data width, with the largest latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a run when the block is idle |
| data_i | input | W | Word whose set bits are counted |
| count_o | output | $clog2(W+1) | Result; reads 0 unless done_o is high |
| done_o | output | 1 | Result valid; held until the next accepted start |

## Verification
A wrong state transition or a bad register-file write shows up at the ports in one of two ways. Either the count is wrong when done_o rises, or done_o rises at a different edge than 4+3n. Checking both the value and the exact latency exposes a loop that exits one pass early or late, or that tests the word before shifting, at the end of the very run that triggered it. A mask or clear that is not rebuilt between runs shows up in the next run, because vectors run back to back without reset.

// File: rtl/bc_pkg.sv
package bc_pkg;
  localparam int RF_AW = 2;
  localparam logic [RF_AW-1:0] RA_WORD = 2'd0;
  localparam logic [RF_AW-1:0] RA_MASK = 2'd1;
  localparam logic [RF_AW-1:0] RA_SUM  = 2'd2;
  localparam logic [RF_AW-1:0] RA_TMP  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_CLR, ST_MASK, ST_AND, ST_ACC, ST_SHIFT, ST_DONE
  } bc_state_e;

  typedef enum logic [2:0] {
    ALU_PASS, ALU_SUB, ALU_INC, ALU_AND, ALU_ADD
  } bc_alu_op_e;

  typedef struct packed {
    logic [RF_AW-1:0] rd_a;
    logic [RF_AW-1:0] rd_b;
    bc_alu_op_e       alu_op;
    logic             shr;
    logic             wr_en;
    logic [RF_AW-1:0] wr_addr;
    logic             wr_from_in;
    logic             out_en;
  } bc_ctrl_t;
endpackage

// File: rtl/bc_regfile.sv
module bc_regfile #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))     mem_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/bc_alu.sv
module bc_alu
  import bc_pkg::*;
#(
  parameter int W = 16
) (
  input  bc_alu_op_e   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_INC: y_o = a_i + W'(1);
      ALU_AND: y_o = a_i & b_i;
      ALU_ADD: y_o = a_i + b_i;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/bc_shifter.sv
module bc_shifter #(
  parameter int W = 16
) (
  input  logic         shr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  assign q_o = shr_i ? {1'b0, d_i[W-1:1]} : d_i;
endmodule

// File: rtl/bc_ctrl.sv
module bc_ctrl
  import bc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      zero_i,   // shifted word is zero
  output bc_state_e state_o,
  output bc_ctrl_t  cw_o
);
  bc_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    cw_o    = '{rd_a: RA_WORD, rd_b: RA_WORD, alu_op: ALU_PASS, shr: 1'b0,
                wr_en: 1'b0, wr_addr: RA_WORD, wr_from_in: 1'b0, out_en: 1'b0};
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_LOAD;
      ST_LOAD: begin
        cw_o.wr_en = 1'b1; cw_o.wr_addr = RA_WORD; cw_o.wr_from_in = 1'b1;
        state_d = ST_CLR;
      end
      ST_CLR: begin
        cw_o.rd_a = RA_SUM; cw_o.rd_b = RA_SUM; cw_o.alu_op = ALU_SUB;
        cw_o.wr_en = 1'b1; cw_o.wr_addr = RA_SUM;
        state_d = ST_MASK;
      end
      ST_MASK: begin
        cw_o.rd_a = RA_SUM; cw_o.alu_op = ALU_INC;
        cw_o.wr_en = 1'b1; cw_o.wr_addr = RA_MASK;
        state_d = ST_AND;
      end
      ST_AND: begin
        cw_o.rd_a = RA_WORD; cw_o.rd_b = RA_MASK; cw_o.alu_op = ALU_AND;
        cw_o.wr_en = 1'b1; cw_o.wr_addr = RA_TMP;
        state_d = ST_ACC;
      end
      ST_ACC: begin
        cw_o.rd_a = RA_SUM; cw_o.rd_b = RA_TMP; cw_o.alu_op = ALU_ADD;
        cw_o.wr_en = 1'b1; cw_o.wr_addr = RA_SUM;
        state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        cw_o.rd_a = RA_WORD; cw_o.shr = 1'b1;
        cw_o.wr_en = 1'b1; cw_o.wr_addr = RA_WORD;
        state_d = zero_i ? ST_DONE : ST_AND;
      end
      ST_DONE: begin
        cw_o.rd_a = RA_SUM; cw_o.out_en = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_o = state_q;
endmodule

// File: rtl/bitcount_seq.sv
module bitcount_seq
  import bc_pkg::*;
#(
  parameter int W   = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  data_i,
  output logic [CW-1:0] count_o,
  output logic          done_o
);
  bc_state_e     state;
  bc_ctrl_t      cw;
  logic [W-1:0]  bus_a, bus_b, alu_y, bus_res, wdata;
  logic [CW-1:0] count_q;
  logic          done_q;

  bc_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .zero_i  (bus_res == '0),
    .state_o (state),
    .cw_o    (cw)
  );

  assign wdata = cw.wr_from_in ? data_i : bus_res;

  bc_regfile #(.W(W), .DEPTH(4)) u_rf (
    .clk_i, .rst_ni,
    .we_i      (cw.wr_en),
    .waddr_i   (cw.wr_addr),
    .wdata_i   (wdata),
    .raddr_a_i (cw.rd_a),
    .raddr_b_i (cw.rd_b),
    .rdata_a_o (bus_a),
    .rdata_b_o (bus_b)
  );

  bc_alu #(.W(W)) u_alu (.op_i(cw.alu_op), .a_i(bus_a), .b_i(bus_b), .y_o(alu_y));

  bc_shifter #(.W(W)) u_shr (.shr_i(cw.shr), .d_i(alu_y), .q_o(bus_res));

  // output port: loaded on the final state, disabled (zero) once a new run starts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      done_q  <= 1'b0;
    end else if (cw.out_en) begin
      count_q <= bus_a[CW-1:0];
      done_q  <= 1'b1;
    end else if (state == ST_IDLE && start_i) begin
      count_q <= '0;
      done_q  <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign done_o  = done_q;
endmodule

// File: rtl/bitcount_seq_chk.sv
module bitcount_seq_chk
  import bc_pkg::*;
#(
  parameter int W   = 16,
  localparam int CW = $clog2(W + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [CW-1:0] count_o,
  input logic          done_o,
  input bc_state_e     state
);
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE && !start_i |=> state == ST_IDLE);
  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE && start_i |=> state == ST_LOAD);
  p_count_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> count_o <= CW'(W));
  p_done_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(count_o));
  p_done_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && start_i |=> !done_o);
  p_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> count_o == '0);
  p_busy_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_LOAD |=> state == ST_CLR);
  p_done_only_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> state == ST_IDLE);
endmodule

bind bitcount_seq bitcount_seq_chk #(.W(W)) u_chk (
  .clk_i, .rst_ni, .start_i, .count_o, .done_o, .state
);

// File: tb/bitcount_seq_tb_top.sv
module bitcount_seq_tb_top;
  localparam int W  = 16;
  localparam int CW = $clog2(W + 1);
  localparam int NV = 8;
  // stimulus word, expected count, expected loop passes
  localparam logic [W-1:0] VD [NV] = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF,
                                        16'h00F0, 16'hA5A5, 16'h0102, 16'h7FFE};
  localparam int VC [NV] = '{0, 1, 1, 16, 4, 8, 2, 14};
  localparam int VN [NV] = '{1, 1, 16, 16, 8, 16, 9, 15};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [W-1:0]  data_i = '0;
  logic [CW-1:0] count_o;
  logic          done_o;
  int tests = 0;
  int fails = 0;

  always #4 clk_i = ~clk_i;

  bitcount_seq #(.W(W)) dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one run; poke > 0 pulses start_i with a corrupted word at that cycle
  task automatic do_run(input logic [W-1:0] d, input int poke, output int cnt, output int lat);
    @(negedge clk_i); data_i = d; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0; lat = 1;
    while (!done_o && lat < 200) begin
      @(negedge clk_i); lat++;
      if (lat == poke) begin start_i = 1'b1; data_i = ~d; end
      else start_i = 1'b0;
    end
    cnt = int'(count_o);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    check(1'b0, "R4 watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cnt, lat;
    repeat (3) @(negedge clk_i);
    check(done_o == 1'b0, "R1 done in reset", int'(done_o), 0);
    check(count_o == '0, "R1 count in reset", int'(count_o), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check(done_o == 1'b0 && count_o == '0, "R1/R2 idle without start", int'(done_o), 0);

    for (int i = 0; i < NV; i++) begin
      do_run(VD[i], 0, cnt, lat);
      check(cnt == VC[i], (i == 0) ? "R5 zero count" : (i == 3) ? "R9 all ones" : "R3 count",
            cnt, VC[i]);
      check(lat == 5 + 3 * VN[i], (i == 0) ? "R5 zero latency" : "R4 latency",
            lat, 5 + 3 * VN[i]);
    end

    // R8: start pulse mid-run with a different word
    do_run(16'h0F0F, 4, cnt, lat);
    check(cnt == 8, "R8 busy start count", cnt, 8);
    check(lat == 41, "R8 busy start latency", lat, 41);

    // R6: hold while start low
    begin
      bit ok = 1'b1;
      repeat (10) begin
        @(negedge clk_i);
        if (!done_o || count_o != CW'(8)) ok = 1'b0;
      end
      check(ok, "R6 result hold", int'(count_o), 8);
    end

    // R6/R7: next start drops done and disables count
    @(negedge clk_i); data_i = 16'h0003; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    check(done_o == 1'b0, "R6 done falls on start", int'(done_o), 0);
    check(count_o == '0, "R7 count disabled", int'(count_o), 0);
    lat = 0;
    while (!done_o && lat < 200) begin @(negedge clk_i); lat++; end
    check(count_o == CW'(2), "R3 count after restart", int'(count_o), 2);

    // R1: reset in the middle of a run
    @(negedge clk_i); data_i = 16'hFFFF; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (6) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(done_o == 1'b0 && count_o == '0, "R1 reset mid-run", int'(count_o), 0);
    rst_ni = 1'b1;
    repeat (60) @(negedge clk_i);
    check(done_o == 1'b0, "R1/R2 idle after reset", int'(done_o), 0);
    do_run(16'h0400, 0, cnt, lat);
    check(cnt == 1 && lat == 38, "R4 run after reset", lat, 38);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule